// File: doc/BRIEF.md
# Serial Receiver with Sticky Error Status

This block turns an asynchronous serial line into bytes. A frame is a low start bit, the data bits least significant first, an optional parity bit, and one stop bit. A 16x oversampling tick paces the receiver. The serial input passes through a two-flop synchronizer. A start is accepted only if the line is still low at the middle of the start bit. After that, each bit is sampled at its centre.

Each completed character is stored in a holding register and sets a ready flag. Three error flags record trouble: overrun, parity and framing. These flags are sticky. Reading the character clears only the ready flag. The error flags clear only when the status-clear strobe is pulsed. The baud-tick source, the bus interface and the interrupt logic all sit outside the block. It exposes plain strobes, the received byte and a four-bit status vector.

Top module: `uart_rx_sticky`

## Requirements
- R1: After reset, `status` is 4'b0000 and `rx_data` is zero. The status bits are: bit 0 ready, bit 1 overrun, bit 2 parity error, bit 3 framing error.
- R2: A frame is received least significant bit first. When its stop bit is sampled, the data bits are stored in `rx_data` and ready is set.
- R3: A pulse on `rd_strobe` clears ready. It leaves `rx_data` unchanged.
- R4: Overrun is set when a character completes while ready is still set. In that case the new character replaces `rx_data` and ready stays 1.
- R5: A read strobe may land in the same cycle as a character completion. Then the completion wins: ready stays 1 and overrun is not set.
- R6: `parity_mode` selects the expected parity bit: 0 gives the even-count bit (XOR of data), 1 gives odd (inverted XOR), 2 forces 0, 3 forces 1. A mismatch sets the parity error flag in the same cycle that ready is set.
- R7: Parity error stays at 1 while later characters with correct parity arrive, until a status clear.
- R8: `parity_mode` values 4 to 7 mean no parity bit. The stop bit follows the last data bit, and parity error is never set.
- R9: A stop bit sampled low sets the framing error flag together with ready. The flag stays 1 until a status clear.
- R10: A pulse on `clr_status` clears overrun, parity error and framing error. It leaves ready and `rx_data` unchanged.
- R11: A low pulse on the line that is shorter than half a bit period is ignored. No character is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_serial | input | 1 | Asynchronous serial line, idle high |
| baud_tick | input | 1 | One pulse per sixteenth of a bit period |
| parity_mode | input | 3 | Parity selection (see R6, R8) |
| rd_strobe | input | 1 | Read of the holding register; clears ready |
| clr_status | input | 1 | Clears the three sticky error flags |
| rx_data | output | DATA_W | Last received character |
| status | output | 4 | {framing, parity, overrun, ready} |

## Verification
The bench aims a read strobe at the exact cycle in which a character completes. A design that let the read win there would drop ready or report a false overrun. It sends a good-parity character after a bad one: a design that recomputed parity error per character would lose the flag. The same applies to overrun and framing error, which a read must not clear. It also checks that, in no-parity mode, the stop bit comes straight after the data bits. A design that still waited for a parity slot would misread the frame. Finally, a short low glitch must be ignored; a receiver that confirmed the start too early would deliver a phantom byte.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
    typedef enum logic [2:0] {
        PM_EVEN = 3'd0,
        PM_ODD  = 3'd1,
        PM_ZERO = 3'd2,
        PM_ONE  = 3'd3
    } par_mode_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP
    } rx_state_e;

    function automatic logic mode_has_parity(input logic [2:0] mode);
        return (mode[2] == 1'b0);
    endfunction

    function automatic logic expected_parity(input logic [2:0] mode, input logic odd_sum);
        case (mode)
            PM_EVEN: return odd_sum;
            PM_ODD:  return ~odd_sum;
            PM_ZERO: return 1'b0;
            PM_ONE:  return 1'b1;
            default: return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/rxs_sync.sv
module rxs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/rxs_deser.sv
module rxs_deser
    import rxs_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_s,
    input  logic              tick,
    input  logic [2:0]        par_mode,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              perr,
    output logic              ferr
);
    localparam int CNT_W = (OVS > 2) ? $clog2(OVS) : 1;
    localparam int IDX_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(OVS - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

    typedef struct packed {
        rx_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] shreg;
        logic [2:0]        mode;
        logic              par_en;
        logic              perr_pend;
        logic              done;
        logic [DATA_W-1:0] data;
        logic              perr;
        logic              ferr;
    } deser_t;

    deser_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.state)
            S_IDLE: begin
                if (tick && !rx_s) begin
                    d.state = S_START;
                    d.cnt   = '0;
                end
            end
            S_START: begin
                if (tick) begin
                    if (q.cnt == CNT_HALF) begin
                        d.cnt = '0;
                        if (!rx_s) begin
                            d.state     = S_DATA;
                            d.idx       = '0;
                            d.mode      = par_mode;
                            d.par_en    = mode_has_parity(par_mode);
                            d.perr_pend = 1'b0;
                        end else begin
                            d.state = S_IDLE;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            S_DATA: begin
                if (tick) begin
                    if (q.cnt == CNT_FULL) begin
                        d.cnt   = '0;
                        d.shreg = {rx_s, q.shreg[DATA_W-1:1]};
                        if (q.idx == IDX_LAST) d.state = q.par_en ? S_PAR : S_STOP;
                        else                   d.idx   = q.idx + 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            S_PAR: begin
                if (tick) begin
                    if (q.cnt == CNT_FULL) begin
                        d.cnt       = '0;
                        d.perr_pend = (rx_s != expected_parity(q.mode, ^q.shreg));
                        d.state     = S_STOP;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            S_STOP: begin
                if (tick) begin
                    if (q.cnt == CNT_FULL) begin
                        d.cnt   = '0;
                        d.done  = 1'b1;
                        d.data  = q.shreg;
                        d.perr  = q.perr_pend;
                        d.ferr  = !rx_s;
                        d.state = S_IDLE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            default: d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: S_IDLE, mode: 3'd0, default: '0};
        else        q <= d;
    end

    assign done = q.done;
    assign data = q.data;
    assign perr = q.perr;
    assign ferr = q.ferr;

    // R2: a completion pulse follows only a stop-bit sample
    p_done_after_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> $past(q.state == S_STOP));

    // R8: with no parity slot a completion never carries a parity error
    p_no_perr_without_parity_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && !q.par_en) |-> !q.perr);

    // R11: a confirmed start leads into data, never straight to stop
    p_start_to_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == S_START && d.state != S_START) |-> (d.state == S_DATA || d.state == S_IDLE));
endmodule

// File: rtl/uart_rx_sticky.sv
module uart_rx_sticky
    import rxs_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_serial,
    input  logic              baud_tick,
    input  logic [2:0]        parity_mode,
    input  logic              rd_strobe,
    input  logic              clr_status,
    output logic [DATA_W-1:0] rx_data,
    output logic [3:0]        status
);
    logic              rx_s;
    logic              char_done;
    logic [DATA_W-1:0] char_data;
    logic              char_perr;
    logic              char_ferr;

    rxs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_serial),
        .dout (rx_s)
    );

    rxs_deser #(.DATA_W(DATA_W), .OVS(OVS)) u_deser (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_s    (rx_s),
        .tick    (baud_tick),
        .par_mode(parity_mode),
        .done    (char_done),
        .data    (char_data),
        .perr    (char_perr),
        .ferr    (char_ferr)
    );

    typedef struct packed {
        logic [DATA_W-1:0] hold;
        logic              rdy;
        logic              ovr;
        logic              par;
        logic              frm;
    } stat_t;

    stat_t q, d;

    always_comb begin
        d = q;
        if (clr_status) begin
            d.ovr = 1'b0;
            d.par = 1'b0;
            d.frm = 1'b0;
        end
        if (char_done) begin
            d.hold = char_data;
            d.rdy  = 1'b1;
            if (q.rdy && !rd_strobe) d.ovr = 1'b1;
            if (char_perr)           d.par = 1'b1;
            if (char_ferr)           d.frm = 1'b1;
        end else if (rd_strobe) begin
            d.rdy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_data = q.hold;
    assign status  = {q.frm, q.par, q.ovr, q.rdy};

    p_ready_on_char_r2: assert property (@(posedge clk) disable iff (!rst_n)
        char_done |=> status[0]);

    p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !char_done) |=> (!status[0] && $stable(rx_data)));

    p_overrun_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && status[0] && !rd_strobe) |=> status[1]);

    p_same_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && rd_strobe && (!status[1] || clr_status)) |=> (status[0] && !status[1]));

    p_par_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (status[2] && !clr_status) |=> status[2]);

    p_frame_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (status[3] && !clr_status) |=> status[3]);

    p_clear_errs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_status && !char_done) |=> (status[3:1] == 3'b000 && $stable(rx_data)));

    p_errs_only_on_char_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(status[2]) || $rose(status[3])) |-> $past(char_done));
endmodule

// File: tb/uart_rx_sticky_test.sv
module uart_rx_sticky_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_serial = 1'b1;
    logic       baud_tick = 1'b1;
    logic [2:0] parity_mode = 3'd0;
    logic       rd_strobe = 1'b0;
    logic       clr_status = 1'b0;
    logic [7:0] rx_data;
    logic [3:0] status;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    uart_rx_sticky uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_serial  (rx_serial),
        .baud_tick  (baud_tick),
        .parity_mode(parity_mode),
        .rd_strobe  (rd_strobe),
        .clr_status (clr_status),
        .rx_data    (rx_data),
        .status     (status)
    );

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic par_bit(input logic [2:0] mode, input logic [7:0] v);
        case (mode)
            3'd0: return ^v;
            3'd1: return ~^v;
            3'd2: return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    task automatic drive_bit(input logic v);
        rx_serial = v;
        repeat (16) @(negedge clk);
    endtask

    // Start bit edge on a negedge; rd_end fires the read in the completion cycle
    task automatic send_frame(input logic [7:0] v, input bit with_par, input logic pb,
                              input logic stopb, input bit rd_end);
        @(negedge clk);
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) drive_bit(v[i]);
        if (with_par) drive_bit(pb);
        rx_serial = stopb;
        for (int i = 0; i < 16; i++) begin
            rd_strobe = (rd_end && i == 11);
            @(negedge clk);
        end
        rd_strobe = 1'b0;
        rx_serial = 1'b1;
        repeat (20) @(negedge clk);
    endtask

    task automatic do_read();
        @(negedge clk) rd_strobe = 1'b1;
        @(negedge clk) rd_strobe = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk) clr_status = 1'b1;
        @(negedge clk) clr_status = 1'b0;
    endtask

    task automatic t_reset();
        check_eq("R1 status", status, 4'b0000);
        check_eq("R1 data", rx_data, 8'h00);
    endtask

    task automatic t_basic();
        parity_mode = 3'd0;
        send_frame(8'hA5, 1, par_bit(3'd0, 8'hA5), 1'b1, 0);
        check_eq("R2 data A5", rx_data, 8'hA5);
        check_eq("R2 status ready", status, 4'b0001);
        do_read();
        check_eq("R3 ready cleared", status, 4'b0000);
        check_eq("R3 data kept", rx_data, 8'hA5);
        send_frame(8'h3C, 1, par_bit(3'd0, 8'h3C), 1'b1, 0);
        check_eq("R2 data 3C", rx_data, 8'h3C);
        do_read();
    endtask

    task automatic t_overrun();
        send_frame(8'h11, 1, par_bit(3'd0, 8'h11), 1'b1, 0);
        send_frame(8'h82, 1, par_bit(3'd0, 8'h82), 1'b1, 0);
        check_eq("R4 overwritten", rx_data, 8'h82);
        check_eq("R4 ready+overrun", status, 4'b0011);
        do_read();
        check_eq("R4 overrun sticky after read", status, 4'b0010);
        do_clear();
        check_eq("R10 overrun cleared", status, 4'b0000);
    endtask

    task automatic t_same_cycle();
        send_frame(8'h5A, 1, par_bit(3'd0, 8'h5A), 1'b1, 0);
        send_frame(8'hC3, 1, par_bit(3'd0, 8'hC3), 1'b1, 1);
        check_eq("R5 data", rx_data, 8'hC3);
        check_eq("R5 ready, no overrun", status, 4'b0001);
        do_read();
    endtask

    task automatic t_parity();
        parity_mode = 3'd1;
        send_frame(8'h96, 1, par_bit(3'd1, 8'h96), 1'b1, 0);
        check_eq("R6 odd good", status, 4'b0001);
        do_read();
        send_frame(8'h97, 1, ~par_bit(3'd1, 8'h97), 1'b1, 0);
        check_eq("R6 odd bad", status, 4'b0101);
        do_read();
        send_frame(8'h40, 1, par_bit(3'd1, 8'h40), 1'b1, 0);
        check_eq("R7 parity sticky", status, 4'b0101);
        check_eq("R7 data", rx_data, 8'h40);
        do_clear();
        check_eq("R10 ready and data kept", status, 4'b0001);
        check_eq("R10 data", rx_data, 8'h40);
        do_read();
        parity_mode = 3'd2;
        send_frame(8'hFF, 1, 1'b1, 1'b1, 0);
        check_eq("R6 forced zero mismatch", status, 4'b0101);
        do_read(); do_clear();
        parity_mode = 3'd3;
        send_frame(8'h00, 1, 1'b1, 1'b1, 0);
        check_eq("R6 forced one match", status, 4'b0001);
        do_read();
        parity_mode = 3'd0;
        send_frame(8'h07, 1, ~par_bit(3'd0, 8'h07), 1'b1, 0);
        check_eq("R6 even mismatch", status, 4'b0101);
        do_read(); do_clear();
    endtask

    task automatic t_none();
        parity_mode = 3'd4;
        send_frame(8'h6E, 0, 1'b0, 1'b1, 1);
        check_eq("R8 no-parity data", rx_data, 8'h6E);
        check_eq("R8 no parity error", status, 4'b0001);
        do_read();
        parity_mode = 3'd7;
        send_frame(8'h01, 0, 1'b0, 1'b1, 0);
        check_eq("R8 mode 7 no parity", status, 4'b0001);
        check_eq("R8 mode 7 data", rx_data, 8'h01);
        do_read();
        parity_mode = 3'd0;
    endtask

    task automatic t_framing();
        send_frame(8'h24, 1, par_bit(3'd0, 8'h24), 1'b0, 0);
        check_eq("R9 framing set", status, 4'b1001);
        do_read();
        send_frame(8'h25, 1, par_bit(3'd0, 8'h25), 1'b1, 0);
        check_eq("R9 framing sticky", status, 4'b1001);
        do_read();
        do_clear();
        check_eq("R10 framing cleared", status, 4'b0000);
    endtask

    task automatic t_glitch();
        @(negedge clk) rx_serial = 1'b0;
        repeat (4) @(negedge clk);
        rx_serial = 1'b1;
        repeat (200) @(negedge clk);
        check_eq("R11 glitch ignored status", status, 4'b0000);
        check_eq("R11 glitch data kept", rx_data, 8'h25);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_basic();
        t_overrun();
        t_same_cycle();
        t_parity();
        t_none();
        t_framing();
        t_glitch();
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end
endmodule